// File: doc/BRIEF.md
# Stall-Aware Program Counter and Fetch Stage

This block is the front end of a single-cycle 32-bit core. It holds the program counter, presents it as the fetch address, and picks the counter's next value on every rising clock edge. The next value is one of three: the sequential address four bytes on, a redirect target from a later stage, or the current value again when the instruction memory has not yet returned its data.

The fetched word goes straight on to decode. While the memory reports its data as not valid, decode is given the canonical no-operation word instead, so a stalled cycle retires nothing. The memory side behaves like a stream source with a valid flag and no ready: the fetch stage always accepts valid data in the cycle it arrives, and it applies back-pressure only by keeping the same address on the bus until valid returns. Decode has no ready either and cannot stall fetch.

Top module: `pc_fetch_stage`

## Requirements
- R1: A synchronous reset, active high and sampled at the rising edge, loads the counter with 0x0000_1000; the fetch address reads 0x0000_1000 in the cycle after that edge.
- R2: When memory data is valid and the redirect request is high, the counter takes the redirect target at the next rising edge, with bit 0 of the target forced to zero.
- R3: When memory data is valid and no redirect is requested, the counter advances by 4 at the next rising edge, wrapping modulo 2^32 (0xFFFF_FFFC is followed by 0x0000_0000).
- R4: When memory data is not valid, the counter keeps its value at the next rising edge, and a redirect request in that cycle has no effect.
- R5: When memory data is not valid, the word passed to decode is 0x0000_0013 (add-immediate of zero into register zero), whatever the read data holds.
- R6: When memory data is valid, the word passed to decode equals the read data in the same cycle.
- R7: The fetch address equals the counter in every cycle.
- R8: The counter changes only at a rising clock edge; raising reset between edges leaves the fetch address unchanged until the next edge.
- R9: Bit 0 of the counter is zero in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| redirect_req | input | 1 | Request to load the counter from redirect_target |
| redirect_target | input | 32 | Byte address to continue fetching from |
| imem_valid | input | 1 | Instruction memory read data is valid this cycle |
| imem_rdata | input | 32 | Instruction word from memory |
| fetch_addr | output | 32 | Address presented to instruction memory (the counter) |
| decode_insn | output | 32 | Word handed to decode: read data, or the no-operation word on a stall |

## Verification
Every cycle, the assertions check the counter's step from one edge to the next (reset vector, redirect with the low bit cleared, sequential advance, hold on stall), that the decode word is either the read data or the no-operation word according to the valid flag, and that the counter stays halfword-aligned. Only the bench scenarios show the interplay across sequences: a redirect requested during a stall being dropped and then honoured once valid returns, address wrap at the top of the space, and reset raised between edges leaving the address untouched until the edge.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  // Width of an address and of an instruction word.
  localparam int unsigned XLEN = 32;

  // Byte distance between consecutive instructions.
  localparam int unsigned INSN_BYTES = 4;

  // Canonical no-operation: add-immediate, rd=x0, rs1=x0, imm=0.
  localparam logic [XLEN-1:0] NOP_WORD = 32'h0000_0013;

  // Source chosen for the next counter value.
  typedef enum logic [1:0] {
    PC_SRC_HOLD = 2'd0,
    PC_SRC_SEQ  = 2'd1,
    PC_SRC_JUMP = 2'd2
  } pc_src_e;

endpackage

// File: rtl/pc_next_select.sv
module pc_next_select
  import fetch_pkg::*;
#(
  parameter int unsigned AW          = XLEN,
  parameter int unsigned STEP        = INSN_BYTES,
  parameter int unsigned ALIGN_CLEAR = 1
) (
  input  logic          mem_ok,
  input  logic          jump_req,
  input  logic [AW-1:0] jump_addr,
  input  logic [AW-1:0] pc_now,
  output pc_src_e       src,
  output logic [AW-1:0] pc_next
);

  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic [AW-1:0] target_aligned;
  logic [AW-1:0] seq_addr;

  // Clear the low bits of the redirect target when requested.
  generate
    if (ALIGN_CLEAR > 0) begin : g_align
      localparam logic [AW-1:0] ALIGN_MASK = ~((AW'(1) << ALIGN_CLEAR) - AW'(1));
      assign target_aligned = jump_addr & ALIGN_MASK;
    end else begin : g_noalign
      assign target_aligned = jump_addr;
    end
  endgenerate

  assign seq_addr = pc_now + STEP_V;

  // A stall outranks a redirect.
  always_comb begin
    if (!mem_ok)       src = PC_SRC_HOLD;
    else if (jump_req) src = PC_SRC_JUMP;
    else               src = PC_SRC_SEQ;
  end

  always_comb begin
    unique case (src)
      PC_SRC_JUMP: pc_next = target_aligned;
      PC_SRC_SEQ:  pc_next = seq_addr;
      default:     pc_next = pc_now;
    endcase
  end

endmodule

// File: rtl/pc_register.sv
module pc_register
  import fetch_pkg::*;
#(
  parameter int unsigned   AW       = XLEN,
  parameter logic [AW-1:0] RESET_PC = 32'h0000_1000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] pc_d,
  output logic [AW-1:0] pc_q
);

  always_ff @(posedge clk) begin
    if (rst) pc_q <= RESET_PC;
    else     pc_q <= pc_d;
  end

  // R1: the reset vector appears one edge after reset is sampled.
  a_r1_reset_vector: assert property (@(posedge clk) rst |=> (pc_q == RESET_PC));

  // R9: the counter never holds an odd address once out of reset.
  a_r9_pc_aligned: assert property (@(posedge clk) disable iff (rst) (pc_q[0] == 1'b0));

endmodule

// File: rtl/insn_gate.sv
module insn_gate
  import fetch_pkg::*;
#(
  parameter int unsigned     IW       = XLEN,
  parameter logic [IW-1:0]   BUBBLE   = NOP_WORD
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mem_ok,
  input  logic [IW-1:0] mem_word,
  output logic [IW-1:0] insn_out
);

  assign insn_out = mem_ok ? mem_word : BUBBLE;

  // R5: a stalled cycle hands decode the bubble word.
  a_r5_bubble_on_stall: assert property (@(posedge clk) disable iff (rst)
    !mem_ok |-> (insn_out == BUBBLE));

  // R6: valid data passes through unchanged.
  a_r6_pass_valid: assert property (@(posedge clk) disable iff (rst)
    mem_ok |-> (insn_out == mem_word));

endmodule

// File: rtl/pc_fetch_stage.sv
module pc_fetch_stage
  import fetch_pkg::*;
#(
  parameter int unsigned       AW          = XLEN,
  parameter logic [AW-1:0]     RESET_PC    = 32'h0000_1000,
  parameter int unsigned       ALIGN_CLEAR = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          redirect_req,
  input  logic [AW-1:0] redirect_target,
  input  logic          imem_valid,
  input  logic [AW-1:0] imem_rdata,
  output logic [AW-1:0] fetch_addr,
  output logic [AW-1:0] decode_insn
);

  localparam logic [AW-1:0] STEP_V = AW'(INSN_BYTES);

  logic [AW-1:0] pc_q;
  logic [AW-1:0] pc_d;
  pc_src_e       pc_src;

  pc_next_select #(
    .AW         (AW),
    .STEP       (INSN_BYTES),
    .ALIGN_CLEAR(ALIGN_CLEAR)
  ) u_sel (
    .mem_ok   (imem_valid),
    .jump_req (redirect_req),
    .jump_addr(redirect_target),
    .pc_now   (pc_q),
    .src      (pc_src),
    .pc_next  (pc_d)
  );

  pc_register #(
    .AW      (AW),
    .RESET_PC(RESET_PC)
  ) u_pc (
    .clk (clk),
    .rst (rst),
    .pc_d(pc_d),
    .pc_q(pc_q)
  );

  insn_gate #(
    .IW    (AW),
    .BUBBLE(NOP_WORD)
  ) u_gate (
    .clk     (clk),
    .rst     (rst),
    .mem_ok  (imem_valid),
    .mem_word(imem_rdata),
    .insn_out(decode_insn)
  );

  assign fetch_addr = pc_q;

  // R4: a stall keeps the address, redirect or not.
  a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (!imem_valid && !$past(rst)) |=> (fetch_addr == $past(fetch_addr)));

  // R3: valid without redirect steps by one instruction.
  a_r3_sequential: assert property (@(posedge clk) disable iff (rst)
    (imem_valid && !redirect_req) |=> (fetch_addr == $past(fetch_addr) + STEP_V));

  // R2: valid with redirect lands on the target, low bit cleared.
  a_r2_redirect: assert property (@(posedge clk) disable iff (rst)
    (imem_valid && redirect_req) |=> (fetch_addr == {$past(redirect_target[AW-1:1]), 1'b0}));

endmodule

// File: tb/tb_pc_fetch_stage.sv
module tb_pc_fetch_stage;

  localparam logic [31:0] RST_PC = 32'h0000_1000;
  localparam logic [31:0] NOP    = 32'h0000_0013;
  localparam int          NVEC   = 12;

  // {valid, jump, target, rdata}
  localparam logic [65:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 32'h0000_0000, 32'h02A0_0513},
    {1'b1, 1'b0, 32'h0000_0000, 32'h0000_8067},
    {1'b0, 1'b0, 32'h0000_0000, 32'hDEAD_BEEF},
    {1'b0, 1'b1, 32'h0000_2000, 32'h1234_5678},
    {1'b1, 1'b1, 32'h0000_102C, 32'h0000_0293},
    {1'b1, 1'b0, 32'h0000_0000, 32'h0030_0313},
    {1'b1, 1'b1, 32'h0000_3001, 32'hFFFF_FFFF},
    {1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000},
    {1'b1, 1'b0, 32'h0000_0000, 32'h0000_0067},
    {1'b1, 1'b1, 32'hFFFF_FFFD, 32'hABCD_0001},
    {1'b1, 1'b0, 32'h0000_0000, 32'h0000_0001},
    {1'b1, 1'b0, 32'h0000_0000, 32'h7777_7777}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        redirect_req;
  logic [31:0] redirect_target;
  logic        imem_valid;
  logic [31:0] imem_rdata;
  logic [31:0] fetch_addr;
  logic [31:0] decode_insn;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [31:0] model_pc;

  always #2 clk = ~clk;

  pc_fetch_stage dut (
    .clk            (clk),
    .rst            (rst),
    .redirect_req   (redirect_req),
    .redirect_target(redirect_target),
    .imem_valid     (imem_valid),
    .imem_rdata     (imem_rdata),
    .fetch_addr     (fetch_addr),
    .decode_insn    (decode_insn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Drive one cycle at the falling edge, check combinational outputs,
  // then step the model across the rising edge.
  task automatic step(input logic v, input logic j, input logic [31:0] t,
                      input logic [31:0] d);
    @(negedge clk);
    imem_valid = v; redirect_req = j; redirect_target = t; imem_rdata = d;
    #1;
    check("R7 addr", fetch_addr, model_pc);
    if (v) check("R6 pass", decode_insn, d);
    else   check("R5 nop",  decode_insn, NOP);
    if (!v)     model_pc = model_pc;           // R4
    else if (j) model_pc = {t[31:1], 1'b0};    // R2
    else        model_pc = model_pc + 32'd4;   // R3
    @(posedge clk);
    #1;
    check("R2/R3/R4 next", fetch_addr, model_pc);
    check("R9 align", {31'd0, fetch_addr[0]}, 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; redirect_req = 1'b0; redirect_target = '0;
    imem_valid = 1'b0; imem_rdata = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", fetch_addr, RST_PC);
    @(negedge clk);
    rst = 1'b0;
    model_pc = RST_PC;

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][65], VEC[i][64], VEC[i][63:32], VEC[i][31:0]);
    end

    // R4: long stall with a redirect held high throughout.
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, 32'h0000_8000, 32'h0BAD_0BAD);
    // Redirect honoured once valid returns.
    step(1'b1, 1'b1, 32'h0000_8000, 32'h0000_0013);

    // R3 wrap: jump to the top word, then advance.
    step(1'b1, 1'b1, 32'hFFFF_FFFC, 32'h1);
    step(1'b1, 1'b0, 32'h0, 32'h2);
    check("R3 wrap", fetch_addr, 32'h0000_0000);

    // R8: reset raised between edges leaves the address alone until the edge.
    @(negedge clk);
    imem_valid = 1'b0; redirect_req = 1'b0;
    rst = 1'b1;
    #1;
    check("R8 no async", fetch_addr, model_pc);
    @(posedge clk);
    #1;
    check("R1 R8 sync reset", fetch_addr, RST_PC);
    @(negedge clk);
    rst = 1'b0;
    model_pc = RST_PC;
    step(1'b1, 1'b0, 32'h0, 32'h0000_0093);
    check("R1 after reset step", fetch_addr, RST_PC + 32'd4);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule